// File: doc/BRIEF.md
# Closed Half-Buffer Token Ring

This block is a cycle-level model of a closed loop of `S` half-buffer pipeline stages. It shows how a clocked feedback loop of registers behaves once it has been turned into a fine-grain self-timed pipeline. Each stage holds either a spacer or a data token. A stage copies its predecessor only when the predecessor differs from it and its successor has caught up with it. Under this rule distinct tokens always stay apart, with at least one spacer between them, and they never overtake one another.

Each clocked source register maps to a token stage and a spacer stage. The initial layout is set by a per-stage token mask and by a list of initial values, given in ascending stage order. Only one enabled stage fires per clock. The stage is picked by a rotating-priority pointer or by a pseudo-random start point, which models propagation that is independent and unsynchronised. A stall input freezes the ring. One stage, chosen by a parameter, is brought out as an observation port. A configuration flag reports layouts that break the capacity or spacing bounds. A deadlock flag reports a ring in which no stage has been able to fire for a run-time number of cycles.

Top module: `hb_token_ring`

## Requirements
- R1: During reset and in the first cycle after it, `stage_full[i]` equals bit i of `TOKEN_MASK`. `stage_data[i*W +: W]` holds the n-th W-bit slot of `INIT_VALS` for the n-th masked stage, counted from stage 0 upward. Spacer stages read zero data.
- R2: Stage i is enabled when its fullness differs from that of stage i-1 and equals that of stage i+1, with indices wrapping around. When stage i fires it copies the fullness of stage i-1, and also its value if that stage is full. A stage that does not fire keeps its contents.
- R3: At most one stage fires per cycle, shown one-hot on `fire_vec`. It is always an enabled stage, and some stage fires whenever any stage is enabled and `stall` is low. The pick uses rotating priority when `PICK_MODE` is round-robin and an LFSR-chosen start point when it is pseudo-random.
- R4: While `stall` is high no stage fires, and every stage's fullness and value stay unchanged.
- R5: Two adjacent full stages always hold the same value, so distinct tokens are separated by spacers. The number of tokens (runs of full stages) never changes.
- R6: The values loaded into stage `OBS_STAGE` follow the order of a clocked register loop with the same contents. First comes the token nearest upstream, then each token further back in turn, repeating cyclically.
- R7: `obs_take` is high in exactly the cycle whose closing edge loads a token into stage `OBS_STAGE`, and `obs_data` then carries that token's value.
- R8: From the first cycle after reset, `cfg_bad` is 1 if `S` is less than 3, if the mask holds no token or more than S/2-1 tokens, or if two mask bits are adjacent (wrapping around). Otherwise it is 0.
- R9: `deadlock` rises once no stage has been enabled for `idle_limit` consecutive clocks since reset or since the last enabled cycle, and it clears when a stage becomes enabled. `idle_limit` must be at least 1.
- R10: A ring with a legal configuration never raises `deadlock`, even while stalled, and its tokens keep reaching the observation stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the initial layout |
| stall | input | 1 | Freezes all stage firing while high |
| idle_limit | input | CW | Number of fire-free cycles that flags a deadlock |
| stage_full | output | S | Bit i is 1 when stage i holds a token |
| stage_data | output | S*W | Value of stage i at bits i*W +: W, zero for spacers |
| fire_vec | output | S | One-hot stage that fires at the coming edge |
| obs_take | output | 1 | Observation stage loads a token at the coming edge |
| obs_data | output | W | Value of the token being loaded into the observation stage |
| deadlock | output | 1 | No stage has been enabled for idle_limit cycles |
| cfg_bad | output | 1 | Initial layout breaks the capacity or spacing bounds |

## Verification
The main ring is filled to its capacity bound with three distinct values, so a lost, duplicated or overtaking token changes the stream seen at the observation stage. That stream is checked against the cyclic order of a register loop. The check is repeated under stall bursts of varied lengths, which separate a true freeze from a stall that leaks firing, and again for a second copy that uses the pseudo-random pick, which shows that the order does not depend on the firing schedule. A third copy, with one token too many, is packed so tightly that nothing can fire. This separates the configuration flag and the exact deadlock cycle from a stalled legal ring, which must not be reported as deadlocked.

// File: rtl/hb_ring_pkg.sv
// Shared definitions for the half-buffer token ring: stage-pick policy and
// ring index helpers. Assumes ring lengths of at least one stage.
package hb_ring_pkg;

    // Policy used to choose which enabled stage fires in a cycle.
    typedef enum logic [0:0] {
        PICK_ROUND_ROBIN   = 1'b0,
        PICK_PSEUDO_RANDOM = 1'b1
    } pick_mode_e;

    // Index of the stage feeding stage idx in a ring of len stages.
    function automatic int ring_prev(input int idx, input int len);
        return (idx == 0) ? len - 1 : idx - 1;
    endfunction

    // Index of the stage fed by stage idx in a ring of len stages.
    function automatic int ring_next(input int idx, input int len);
        return (idx == len - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/hb_ring_stage.sv
// One half-buffer stage. It holds a spacer (full = 0) or a W-bit token
// (full = 1), so a 1-bit lane has the three states null / zero / one.
// It is enabled when its predecessor differs from it and its successor
// matches it. On fire it copies the predecessor. Assumes fire is only
// given to an enabled stage.
module hb_ring_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_full,
    input  logic [W-1:0] init_data,
    input  logic         pred_full,
    input  logic [W-1:0] pred_data,
    input  logic         succ_full,
    input  logic [W-1:0] succ_data,
    input  logic         fire,
    output logic         enabled,
    output logic         full,
    output logic [W-1:0] data
);

    // Firing condition: new wave upstream, and downstream has absorbed ours.
    always_comb begin
        enabled = (pred_full != full) && (succ_full == full);
    end

    // Stage state: reset layout, otherwise copy predecessor when fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= init_full;
            data <= init_full ? init_data : '0;
        end else if (fire) begin
            full <= pred_full;
            data <= pred_full ? pred_data : '0;
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(full) && $stable(data)));

    // R2
    flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (full != $past(full)));

    // R5
    sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && succ_full) |-> (data == succ_data));

endmodule

// File: rtl/hb_ring_picker.sv
// Chooses at most one enabled stage per cycle. The search starts at a
// start index and walks forward around the ring. The start index is a
// rotating pointer (round-robin) or an LFSR sample (pseudo-random),
// chosen by MODE. Both advance only when a stage actually fires.
module hb_ring_picker
    import hb_ring_pkg::*;
#(
    parameter int         S    = 8,
    parameter pick_mode_e MODE = PICK_ROUND_ROBIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [S-1:0] enabled,
    input  logic         advance,
    output logic [S-1:0] grant
);

    localparam int IW = (S > 1) ? $clog2(S) : 1;

    logic [IW-1:0] start_idx;

    // First enabled stage at or after start_idx, wrapping around the ring.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < S; k++) begin
            int          cand;
            logic [IW-1:0] cidx;
            cand = int'(start_idx) + k;
            if (cand >= S) cand = cand - S;
            cidx = IW'(cand);
            if (!found && enabled[cidx]) begin
                found       = 1'b1;
                grant[cidx] = 1'b1;
            end
        end
    end

    generate
        if (MODE == PICK_ROUND_ROBIN) begin : g_rr
            logic [IW-1:0] ptr_q;
            logic [IW-1:0] ptr_nxt;

            // Next pointer: the stage just after the granted one.
            always_comb begin
                ptr_nxt = ptr_q;
                for (int i = 0; i < S; i++) begin
                    if (grant[i]) ptr_nxt = (i == S - 1) ? '0 : IW'(i + 1);
                end
            end

            // Rotating priority pointer, moved on each fire.
            always_ff @(posedge clk) begin
                if (!rst_n)       ptr_q <= '0;
                else if (advance) ptr_q <= ptr_nxt;
            end

            assign start_idx = ptr_q;
        end else begin : g_lfsr
            logic [15:0] lfsr_q;

            // Galois LFSR stepping once per fire.
            always_ff @(posedge clk) begin
                if (!rst_n)       lfsr_q <= 16'hACE1;
                else if (advance) lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
            end

            assign start_idx = IW'(lfsr_q % 16'(S));
        end
    endgenerate

    // R3
    grant_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~enabled) == '0));

    // R3
    work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|enabled) |-> (|grant));

endmodule

// File: rtl/hb_ring_watch.sv
// Ring health monitor. It captures, at reset, whether the token layout
// breaks the bounds: fewer than 3 stages, no token, more than S/2-1
// tokens, or adjacent tokens. It also counts consecutive cycles with no
// enabled stage and flags a deadlock at idle_limit. Assumes
// idle_limit >= 1 and held steady.
module hb_ring_watch #(
    parameter int           S          = 8,
    parameter logic [S-1:0] TOKEN_MASK = '0,
    parameter int           CW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_enabled,
    input  logic [CW-1:0] idle_limit,
    output logic          deadlock,
    output logic          cfg_bad
);

    // Layout legality, evaluated at elaboration.
    function automatic logic layout_illegal();
        logic [S-1:0] rot;
        int           tokens;
        rot    = {TOKEN_MASK[0], TOKEN_MASK[S-1:1]};
        tokens = $countones(TOKEN_MASK);
        return (S < 3) || (tokens == 0) || (tokens > S / 2 - 1) || (|(TOKEN_MASK & rot));
    endfunction

    localparam logic LAYOUT_BAD = layout_illegal();

    logic [CW-1:0] idle_cnt;
    logic          cfg_bad_q;

    // Consecutive no-enable cycle counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idle_cnt <= '0;
        else if (any_enabled)       idle_cnt <= '0;
        else if (idle_cnt != '1)    idle_cnt <= idle_cnt + 1'b1;
    end

    // Configuration verdict captured while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_bad_q <= LAYOUT_BAD;
    end

    assign deadlock = (idle_cnt >= idle_limit);
    assign cfg_bad  = cfg_bad_q;

    // R9
    live_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_enabled && idle_limit != '0) |=> !deadlock);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cfg_bad));

endmodule

// File: rtl/hb_token_ring.sv
// Closed ring of S half-buffer stages circulating tokens toward rising
// index (S-1 wraps to 0). The initial layout comes from TOKEN_MASK, with
// values taken from INIT_VALS in ascending stage order. One enabled
// stage fires per unstalled cycle. OBS_STAGE is brought out as an
// observation port. Assumes OBS_STAGE < S.
module hb_token_ring
    import hb_ring_pkg::*;
#(
    parameter int           S          = 8,
    parameter int           W          = 8,
    parameter logic [S-1:0] TOKEN_MASK = 8'b0010_0101,
    parameter logic [S*W-1:0] INIT_VALS = '0,
    parameter int           OBS_STAGE  = 0,
    parameter pick_mode_e   PICK_MODE  = PICK_ROUND_ROBIN,
    parameter int           CW         = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic [CW-1:0]  idle_limit,
    output logic [S-1:0]   stage_full,
    output logic [S*W-1:0] stage_data,
    output logic [S-1:0]   fire_vec,
    output logic           obs_take,
    output logic [W-1:0]   obs_data,
    output logic           deadlock,
    output logic           cfg_bad
);

    localparam int OBS_PREV = ring_prev(OBS_STAGE, S);

    // Spread the register list over the masked stages, lowest stage first.
    function automatic logic [S*W-1:0] spread_init();
        logic [S*W-1:0] r;
        int             n;
        r = '0;
        n = 0;
        for (int i = 0; i < S; i++) begin
            if (TOKEN_MASK[i]) begin
                r[i*W +: W] = INIT_VALS[n*W +: W];
                n++;
            end
        end
        return r;
    endfunction

    localparam logic [S*W-1:0] STAGE_INIT = spread_init();

    logic [S-1:0] en_vec;
    logic [S-1:0] grant;
    logic [S-1:0] rise_vec;

    generate
        for (genvar g = 0; g < S; g++) begin : g_stage
            localparam int PV = ring_prev(g, S);
            localparam int NX = ring_next(g, S);

            hb_ring_stage #(.W(W)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .init_full (TOKEN_MASK[g]),
                .init_data (STAGE_INIT[g*W +: W]),
                .pred_full (stage_full[PV]),
                .pred_data (stage_data[PV*W +: W]),
                .succ_full (stage_full[NX]),
                .succ_data (stage_data[NX*W +: W]),
                .fire      (fire_vec[g]),
                .enabled   (en_vec[g]),
                .full      (stage_full[g]),
                .data      (stage_data[g*W +: W])
            );
        end
    endgenerate

    hb_ring_picker #(.S(S), .MODE(PICK_MODE)) u_picker (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (en_vec),
        .advance (|fire_vec),
        .grant   (grant)
    );

    hb_ring_watch #(.S(S), .TOKEN_MASK(TOKEN_MASK), .CW(CW)) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_enabled (|en_vec),
        .idle_limit  (idle_limit),
        .deadlock    (deadlock),
        .cfg_bad     (cfg_bad)
    );

    // Gate the pick with stall and derive the observation view.
    always_comb begin
        fire_vec = grant & {S{~stall}};
        obs_take = fire_vec[OBS_STAGE] & ~stage_full[OBS_STAGE];
        obs_data = stage_data[OBS_PREV*W +: W];
        rise_vec = stage_full & ~{stage_full[S-2:0], stage_full[S-1]};
    end

    // R3
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_vec));

    // R4
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(stage_full) && $stable(stage_data)));

    // R5
    safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(rise_vec) == $past($countones(rise_vec))));

    // R7
    obs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        obs_take |=> (stage_full[OBS_STAGE] && stage_data[OBS_STAGE*W +: W] == $past(obs_data)));

endmodule

// File: tb/hb_token_ring_tb.sv
module hb_token_ring_tb;
    import hb_ring_pkg::*;

    localparam int S = 8;
    localparam int W = 8;
    localparam int CW = 16;
    localparam logic [S-1:0]   MASK = 8'b0010_0101;
    localparam logic [S*W-1:0] VALS = 64'h0000_0000_0033_2211;
    localparam logic [S*W-1:0] RESET_DATA = 64'h0000_3300_0022_0011;
    localparam int OBS = 4;
    localparam int NB = 6;
    localparam int NVEC = 12;

    // {stall cycles before waiting, expected value at the observation stage}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd0, 8'h22}, {8'd3, 8'h11}, {8'd0, 8'h33}, {8'd1, 8'h22},
        {8'd5, 8'h11}, {8'd0, 8'h33}, {8'd2, 8'h22}, {8'd0, 8'h11},
        {8'd0, 8'h33}, {8'd4, 8'h22}, {8'd0, 8'h11}, {8'd1, 8'h33}
    };
    localparam logic [7:0] ORDER [3] = '{8'h22, 8'h11, 8'h33};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b1;
    logic [CW-1:0] idle_limit = 16'd10;

    always #10 clk = ~clk;

    logic [S-1:0] d_full, d_fire, l_full, l_fire;
    logic [S*W-1:0] d_data, l_data;
    logic d_take, d_dead, d_cfg, l_take, l_dead, l_cfg;
    logic [W-1:0] d_odata, l_odata;
    logic [NB-1:0] b_full, b_fire;
    logic [NB*W-1:0] b_data;
    logic b_take, b_dead, b_cfg;
    logic [W-1:0] b_odata;

    hb_token_ring #(.S(S), .W(W), .TOKEN_MASK(MASK), .INIT_VALS(VALS), .OBS_STAGE(OBS),
                    .PICK_MODE(PICK_ROUND_ROBIN), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .idle_limit(idle_limit),
        .stage_full(d_full), .stage_data(d_data), .fire_vec(d_fire), .obs_take(d_take),
        .obs_data(d_odata), .deadlock(d_dead), .cfg_bad(d_cfg));

    hb_token_ring #(.S(S), .W(W), .TOKEN_MASK(MASK), .INIT_VALS(VALS), .OBS_STAGE(OBS),
                    .PICK_MODE(PICK_PSEUDO_RANDOM), .CW(CW)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .stall(1'b0), .idle_limit(idle_limit),
        .stage_full(l_full), .stage_data(l_data), .fire_vec(l_fire), .obs_take(l_take),
        .obs_data(l_odata), .deadlock(l_dead), .cfg_bad(l_cfg));

    hb_token_ring #(.S(NB), .W(W), .TOKEN_MASK(6'b010101), .INIT_VALS(48'h0000_000C_0B0A),
                    .OBS_STAGE(1), .PICK_MODE(PICK_ROUND_ROBIN), .CW(CW)) u_bad (
        .clk(clk), .rst_n(rst_n), .stall(1'b0), .idle_limit(idle_limit),
        .stage_full(b_full), .stage_data(b_data), .fire_vec(b_fire), .obs_take(b_take),
        .obs_data(b_odata), .deadlock(b_dead), .cfg_bad(b_cfg));

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    int r2_bad = 0, r3_bad = 0, r5_bad = 0, r6l_bad = 0;
    int l_seen = 0, l_idx = 0;
    bit dead_seen = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pseudo-random copy: stream order at the observation stage (R6, R3).
    always @(negedge clk) begin
        if (rst_n && !done && l_take) begin
            if (l_odata != ORDER[l_idx]) r6l_bad++;
            l_seen++;
            l_idx = (l_idx + 1) % 3;
        end
    end

    // Main ring: firing rule (R2), single fire (R3), separation and token count (R5).
    logic [S-1:0] pf, pfire;
    logic [S*W-1:0] pd;
    bit have_prev = 0;
    always begin
        @(negedge clk);
        #2;
        if (!rst_n) have_prev = 0;
        else begin
            int runs;
            if (have_prev) begin
                for (int i = 0; i < S; i++) begin
                    int p;
                    p = (i + S - 1) % S;
                    if (pfire[i]) begin
                        if (d_full[i] !== pf[p] || (pf[p] && d_data[i*W +: W] !== pd[p*W +: W])) r2_bad++;
                    end else if (d_full[i] !== pf[i] || d_data[i*W +: W] !== pd[i*W +: W]) r2_bad++;
                end
            end
            runs = 0;
            for (int i = 0; i < S; i++) begin
                int q;
                q = (i + 1) % S;
                if (d_full[i] && !d_full[(i + S - 1) % S]) runs++;
                if (d_full[i] && d_full[q] && d_data[i*W +: W] !== d_data[q*W +: W]) r5_bad++;
            end
            if (runs != 3) r5_bad++;
            if ($countones(d_fire) > 1 || $countones(l_fire) > 1) r3_bad++;
            if (d_dead || l_dead) dead_seen = 1;
            pf = d_full; pd = d_data; pfire = d_fire; have_prev = 1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [S-1:0] snap_full;
        logic [S*W-1:0] snap_data;
        logic [W-1:0] got;

        repeat (2) @(negedge clk);
        // R1 reset layout
        check(d_full == MASK, "R1 reset fullness", 64'(d_full), 64'(MASK));
        check(d_data == RESET_DATA, "R1 reset values", d_data, RESET_DATA);
        // R8 configuration verdict
        check(d_cfg == 1'b0, "R8 legal layout flag", 64'(d_cfg), 64'd0);
        check(b_cfg == 1'b1, "R8 over-capacity layout flag", 64'(b_cfg), 64'd1);

        rst_n = 1'b1;
        repeat (9) @(negedge clk);
        // R9 deadlock not yet at limit-1 idle cycles
        check(b_dead == 1'b0, "R9 deadlock before limit", 64'(b_dead), 64'd0);
        @(negedge clk);
        check(b_dead == 1'b1, "R9 deadlock at limit", 64'(b_dead), 64'd1);
        // R10 a stalled legal ring is not deadlocked
        check(d_dead == 1'b0, "R10 stalled legal ring", 64'(d_dead), 64'd0);
        // R4 ten stalled cycles left the layout untouched
        check(d_full == MASK && d_data == RESET_DATA, "R4 stall holds layout", d_data, RESET_DATA);
        check(d_cfg == 1'b0 && b_cfg == 1'b1, "R8 flags held after reset", 64'({d_cfg, b_cfg}), 64'd1);

        for (int v = 0; v < NVEC; v++) begin
            int slen;
            slen = int'(VEC[v][15:8]);
            if (slen > 0) begin
                stall = 1'b1;
                #1;
                snap_full = d_full;
                snap_data = d_data;
                repeat (slen) @(negedge clk);
                #1;
                // R4 no firing and no change while stalled
                check(d_fire == '0 && d_full == snap_full && d_data == snap_data,
                      "R4 stall burst", d_data, snap_data);
            end
            stall = 1'b0;
            #1;
            while (!d_take) begin
                @(negedge clk);
                #1;
            end
            got = d_odata;
            // R6 stream order at the observation stage
            check(got == VEC[v][7:0], "R6 observed order", 64'(got), 64'(VEC[v][7:0]));
            @(negedge clk);
            #1;
            // R7 token lands in the observation stage at the announced edge
            check(d_full[OBS] && d_data[OBS*W +: W] == got, "R7 take timing",
                  64'({d_full[OBS], d_data[OBS*W +: W]}), 64'({1'b1, got}));
        end

        repeat (40) @(negedge clk);
        done = 1;
        check(r2_bad == 0, "R2 firing rule", 64'(r2_bad), 64'd0);
        check(r3_bad == 0, "R3 single fire per cycle", 64'(r3_bad), 64'd0);
        check(r5_bad == 0, "R5 separation and token count", 64'(r5_bad), 64'd0);
        check(r6l_bad == 0, "R6 order under pseudo-random pick", 64'(r6l_bad), 64'd0);
        check(l_seen >= 6, "R3 pseudo-random ring progresses", 64'(l_seen), 64'd6);
        check(!dead_seen && l_cfg == 1'b0, "R10 legal rings never deadlock", 64'(dead_seen), 64'd0);
        summary();
        $finish;
    end

endmodule